// File: doc/BRIEF.md
# Staged Conditional Branch Direction Predictor

This block gives a taken or not-taken guess for conditional near branches and keeps that guess cheap for most branches. A branch moves through three classes, one way only. An unseen branch holds no storage and is guessed not-taken. The first taken resolution gives it a tracking entry that always guesses taken. The first time such a branch falls through, it is moved to a dynamic class. In that class a perceptron row, read with the global outcome history, decides the direction.

The front end presents a branch PC on the lookup port. The registered guess appears on the next cycle. The back end reports each resolved conditional branch on the update port with its PC, the real outcome and the outcome that was predicted. That report moves the branch through its classes, trains the perceptron of a dynamic branch, and shifts the outcome into the 26-bit global history. The tracking table is direct-mapped and tagged. Each dynamic entry points at one of 16 perceptron rows, chosen by a hash of the PC.

Top module: `bp_stage_pred`

## Requirements
- R1: A lookup that hits no valid entry with a matching tag returns not-taken. The prediction is valid in the cycle after the lookup cycle.
- R2: An update with outcome taken for a PC with no matching entry writes an entry of the always-taken class at index pc[7:2] with tag pc[31:8]. It replaces whatever that index held. Later lookups of that PC return taken.
- R3: An update with outcome not-taken for a PC with no matching entry changes no entry. An entry with another tag at the same index keeps its prediction.
- R4: An always-taken entry stays always-taken when it resolves taken. When it resolves not-taken it becomes dynamic, and this change trains nothing. A dynamic branch whose row is still all zero predicts taken.
- R5: A dynamic branch predicts taken when the bias plus the sum over i of w[i]*x[i] is zero or more. Here x[i] is +1 when history bit i is 1 and -1 when it is 0. Every update shifts its outcome into history bit 0 and drops bit 25.
- R6: An update of a dynamic branch trains its row when the reported prediction differs from the outcome, or when the magnitude of the sum is 60 or less. Training moves the bias by +1 for taken and -1 for not-taken. It moves each w[i] by +1 when history bit i equals the outcome, and by -1 when it does not.
- R7: The bias and the weights saturate at +31 and -32. They never wrap.
- R8: A lookup in the same cycle as an update is dropped, and the valid flag is low on the next cycle. The update is applied.
- R9: Reset clears every entry, every weight and the history, and it lowers the prediction valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_pc_i | input | 32 | PC of the branch looked up |
| upd_valid_i | input | 1 | Resolved branch report |
| upd_pc_i | input | 32 | PC of the resolved branch |
| upd_taken_i | input | 1 | Real outcome, 1 = taken |
| upd_pred_i | input | 1 | Outcome that was predicted for it |
| pred_valid_o | output | 1 | Prediction valid, one cycle after the lookup |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |

## Verification
The guess for a lookup comes from a register. It is due one cycle after the edge that samples the lookup, and it reflects every update sampled at or before that edge. An update changes class, weights and history at the edge that samples it. The bench drives inputs on the falling edge and reads the guess on the falling edge that follows the sampling rising edge. It never reads in the same cycle as a change. Perceptron results are checked at sums the bench works out from the requirements. It returns the history to zero with not-taken reports of an untracked branch, and it reads at the exact step where the sign flips. This covers the threshold, the saturation limits and the 26-bit window.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    CLS_INV = 2'b00,
    CLS_AT  = 2'b01,
    CLS_DYN = 2'b10
  } cls_e;
endpackage

// File: rtl/bp_dot.sv
module bp_dot #(
  parameter int HIST_W = 26,
  parameter int W_W    = 6,
  parameter int SUM_W  = 12
) (
  input  logic [HIST_W:0][W_W-1:0] row_i,
  input  logic [HIST_W-1:0]        hist_i,
  output logic signed [SUM_W-1:0]  sum_o
);
  logic signed [SUM_W-1:0] ext  [HIST_W];
  logic signed [SUM_W-1:0] term [HIST_W];
  logic signed [SUM_W-1:0] bias_ext;

  assign bias_ext = {{(SUM_W-W_W){row_i[0][W_W-1]}}, row_i[0]};

  for (genvar g = 0; g < HIST_W; g++) begin : g_term
    assign ext[g]  = {{(SUM_W-W_W){row_i[g+1][W_W-1]}}, row_i[g+1]};
    assign term[g] = hist_i[g] ? ext[g] : -ext[g];
  end

  always_comb begin
    sum_o = bias_ext;
    for (int i = 0; i < HIST_W; i++) sum_o = sum_o + term[i];
  end
endmodule

// File: rtl/bp_pcpt_bank.sv
module bp_pcpt_bank #(
  parameter int ROWS   = 16,
  parameter int HIST_W = 26,
  parameter int W_W    = 6,
  parameter int THETA  = 60,
  parameter int SUM_W  = 12,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [HIST_W-1:0]       hist_i,
  input  logic [ROW_W-1:0]        lkp_row_i,
  output logic signed [SUM_W-1:0] lkp_sum_o,
  input  logic                    trn_en_i,
  input  logic [ROW_W-1:0]        trn_row_i,
  input  logic                    trn_taken_i,
  input  logic                    trn_pred_i
);
  localparam logic [W_W-1:0] W_MAX = {1'b0, {(W_W-1){1'b1}}};
  localparam logic [W_W-1:0] W_MIN = {1'b1, {(W_W-1){1'b0}}};

  logic [ROWS-1:0][HIST_W:0][W_W-1:0] wgt_q;
  logic [HIST_W:0][W_W-1:0]           row_nxt;
  logic signed [SUM_W-1:0]            trn_sum;
  logic [SUM_W-1:0]                   trn_mag;
  logic                               trn_fire;

  function automatic logic [W_W-1:0] sat_step(logic [W_W-1:0] w, logic up);
    if (up) return (w == W_MAX) ? w : w + 1'b1;
    else    return (w == W_MIN) ? w : w - 1'b1;
  endfunction

  bp_dot #(.HIST_W(HIST_W), .W_W(W_W), .SUM_W(SUM_W)) u_lkp_dot (
    .row_i (wgt_q[lkp_row_i]),
    .hist_i(hist_i),
    .sum_o (lkp_sum_o)
  );

  bp_dot #(.HIST_W(HIST_W), .W_W(W_W), .SUM_W(SUM_W)) u_trn_dot (
    .row_i (wgt_q[trn_row_i]),
    .hist_i(hist_i),
    .sum_o (trn_sum)
  );

  assign trn_mag  = trn_sum[SUM_W-1] ? -trn_sum : trn_sum;
  assign trn_fire = trn_en_i &&
                    ((trn_pred_i != trn_taken_i) || (trn_mag <= SUM_W'(THETA)));

  always_comb begin
    row_nxt    = wgt_q[trn_row_i];
    row_nxt[0] = sat_step(row_nxt[0], trn_taken_i);
    for (int i = 0; i < HIST_W; i++)
      row_nxt[i+1] = sat_step(row_nxt[i+1], hist_i[i] == trn_taken_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       wgt_q <= '0;
    else if (trn_fire) wgt_q[trn_row_i] <= row_nxt;
  end

  // R6: rows only move on an enabled training update
  a_r6_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trn_en_i |=> $stable(wgt_q));

  for (genvar g = 0; g < ROWS; g++) begin : g_chk
    a_r7_bias_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !($past(wgt_q[g][0]) == W_MAX && wgt_q[g][0] == W_MIN) &&
      !($past(wgt_q[g][0]) == W_MIN && wgt_q[g][0] == W_MAX));
  end
endmodule

// File: rtl/bp_class_table.sv
module bp_class_table
  import bp_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int PC_W   = 32,
  parameter int ROW_W  = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int TAG_W = PC_W - IDX_W - 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PC_W-1:0]  lkp_pc_i,
  output logic             lkp_hit_o,
  output cls_e             lkp_cls_o,
  output logic [ROW_W-1:0] lkp_row_o,
  input  logic             upd_valid_i,
  input  logic [PC_W-1:0]  upd_pc_i,
  input  logic             upd_taken_i,
  output logic             upd_hit_o,
  output cls_e             upd_cls_o,
  output logic [ROW_W-1:0] upd_row_o
);
  cls_e             cls_q [DEPTH];
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [ROW_W-1:0] row_q [DEPTH];
  logic [DEPTH-1:0] vld_vec;

  logic [IDX_W-1:0] lkp_idx, upd_idx;
  logic [TAG_W-1:0] lkp_tag, upd_tag;
  logic [ROW_W-1:0] upd_hash;
  logic             unused_lo;

  assign lkp_idx  = lkp_pc_i[IDX_W+1:2];
  assign lkp_tag  = lkp_pc_i[PC_W-1:IDX_W+2];
  assign upd_idx  = upd_pc_i[IDX_W+1:2];
  assign upd_tag  = upd_pc_i[PC_W-1:IDX_W+2];
  assign upd_hash = upd_pc_i[ROW_W+1:2] ^ upd_pc_i[IDX_W+ROW_W+1:IDX_W+2];
  assign unused_lo = ^{lkp_pc_i[1:0], upd_pc_i[1:0]};

  assign lkp_cls_o = cls_q[lkp_idx];
  assign lkp_row_o = row_q[lkp_idx];
  assign lkp_hit_o = (cls_q[lkp_idx] != CLS_INV) && (tag_q[lkp_idx] == lkp_tag);
  assign upd_cls_o = cls_q[upd_idx];
  assign upd_row_o = row_q[upd_idx];
  assign upd_hit_o = (cls_q[upd_idx] != CLS_INV) && (tag_q[upd_idx] == upd_tag);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        cls_q[i] <= CLS_INV;
        tag_q[i] <= '0;
        row_q[i] <= '0;
      end
    end else if (upd_valid_i) begin
      if (!upd_hit_o) begin
        if (upd_taken_i) begin
          cls_q[upd_idx] <= CLS_AT;
          tag_q[upd_idx] <= upd_tag;
          row_q[upd_idx] <= upd_hash;
        end
      end else if (upd_cls_o == CLS_AT && !upd_taken_i) begin
        cls_q[upd_idx] <= CLS_DYN;
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_vld
    assign vld_vec[g] = (cls_q[g] != CLS_INV);
  end

  // R3: a not-taken report never allocates
  a_r3_nt_no_alloc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && !upd_taken_i |=> $stable(vld_vec));

  // R2: a taken report always leaves a live entry behind
  a_r2_taken_alloc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && upd_taken_i |=> cls_q[$past(upd_idx)] != CLS_INV);
endmodule

// File: rtl/bp_stage_pred.sv
module bp_stage_pred
  import bp_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int TBL_DEPTH = 64,
  parameter int ROWS      = 16,
  parameter int HIST_W    = 26,
  parameter int W_W       = 6,
  parameter int THETA     = 60
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lkp_valid_i,
  input  logic [PC_W-1:0] lkp_pc_i,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i,
  input  logic            upd_pred_i,
  output logic            pred_valid_o,
  output logic            pred_taken_o
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int SUM_W = W_W + $clog2(HIST_W + 1) + 1;

  logic [HIST_W-1:0]       ghr_q;
  logic                    lkp_hit, upd_hit;
  cls_e                    lkp_cls, upd_cls;
  logic [ROW_W-1:0]        lkp_row, upd_row;
  logic signed [SUM_W-1:0] lkp_sum;
  logic                    lkp_fire, taken_c, trn_en;

  bp_class_table #(.DEPTH(TBL_DEPTH), .PC_W(PC_W), .ROW_W(ROW_W)) u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lkp_pc_i   (lkp_pc_i),
    .lkp_hit_o  (lkp_hit),
    .lkp_cls_o  (lkp_cls),
    .lkp_row_o  (lkp_row),
    .upd_valid_i(upd_valid_i),
    .upd_pc_i   (upd_pc_i),
    .upd_taken_i(upd_taken_i),
    .upd_hit_o  (upd_hit),
    .upd_cls_o  (upd_cls),
    .upd_row_o  (upd_row)
  );

  assign trn_en = upd_valid_i && upd_hit && (upd_cls == CLS_DYN);

  bp_pcpt_bank #(
    .ROWS(ROWS), .HIST_W(HIST_W), .W_W(W_W), .THETA(THETA), .SUM_W(SUM_W)
  ) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hist_i     (ghr_q),
    .lkp_row_i  (lkp_row),
    .lkp_sum_o  (lkp_sum),
    .trn_en_i   (trn_en),
    .trn_row_i  (upd_row),
    .trn_taken_i(upd_taken_i),
    .trn_pred_i (upd_pred_i)
  );

  // update port owns the table in a shared cycle
  assign lkp_fire = lkp_valid_i && !upd_valid_i;
  assign taken_c  = lkp_hit && ((lkp_cls == CLS_AT) ||
                                (lkp_cls == CLS_DYN && !lkp_sum[SUM_W-1]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ghr_q        <= '0;
      pred_valid_o <= 1'b0;
      pred_taken_o <= 1'b0;
    end else begin
      if (upd_valid_i) ghr_q <= {ghr_q[HIST_W-2:0], upd_taken_i};
      pred_valid_o <= lkp_fire;
      pred_taken_o <= lkp_fire && taken_c;
    end
  end

  a_r8_upd_over_lkp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> !pred_valid_o);

  a_r1_lkp_answered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_valid_i && !upd_valid_i |=> pred_valid_o);

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_valid_i |=> !pred_valid_o && !pred_taken_o);
endmodule

// File: tb/test_bp_stage_pred.sv
module test_bp_stage_pred;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lkp_valid = 1'b0;
  logic [31:0] lkp_pc = '0;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic        upd_pred = 1'b0;
  logic        pred_valid, pred_taken;

  int n_vec = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  bp_stage_pred i_bp_stage_pred (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .lkp_valid_i (lkp_valid),
    .lkp_pc_i    (lkp_pc),
    .upd_valid_i (upd_valid),
    .upd_pc_i    (upd_pc),
    .upd_taken_i (upd_taken),
    .upd_pred_i  (upd_pred),
    .pred_valid_o(pred_valid),
    .pred_taken_o(pred_taken)
  );

  localparam logic [31:0] PC_A = 32'h0000_1000;  // idx 0, row 0
  localparam logic [31:0] PC_B = 32'h0000_2000;  // idx 0, other tag
  localparam logic [31:0] PC_C = 32'h0000_1004;  // untracked filler
  localparam logic [31:0] PC_D = 32'h0000_3008;  // ones source

  typedef struct packed {
    logic        upd;
    logic [31:0] pc;
    logic        tk;
    logic        pd;
    logic        exp;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{1'b0, PC_A, 1'b0, 1'b0, 1'b0, 4'd1},   // R1 unseen
    '{1'b1, PC_A, 1'b1, 1'b0, 1'b0, 4'd2},
    '{1'b0, PC_A, 1'b0, 1'b0, 1'b1, 4'd2},   // R2 allocated
    '{1'b0, PC_B, 1'b0, 1'b0, 1'b0, 4'd3},   // alias miss
    '{1'b1, PC_B, 1'b0, 1'b0, 1'b0, 4'd3},
    '{1'b0, PC_A, 1'b0, 1'b0, 1'b1, 4'd3},   // R3 entry kept
    '{1'b1, PC_A, 1'b1, 1'b1, 1'b0, 4'd4},
    '{1'b0, PC_A, 1'b0, 1'b0, 1'b1, 4'd4},   // R4 still taken
    '{1'b1, PC_A, 1'b0, 1'b1, 1'b0, 4'd4},   // to dynamic
    '{1'b0, PC_A, 1'b0, 1'b0, 1'b1, 4'd4},   // zero row -> taken
    '{1'b1, PC_C, 1'b0, 1'b0, 1'b0, 4'd3},
    '{1'b0, PC_C, 1'b0, 1'b0, 1'b0, 4'd3}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic do_lookup(input logic [31:0] pc, input string req,
                           input logic exp_taken);
    lkp_valid = 1'b1;
    lkp_pc    = pc;
    @(posedge clk);
    @(negedge clk);
    lkp_valid = 1'b0;
    check({req, " valid"}, pred_valid, 1'b1);
    check(req, pred_taken, exp_taken);
  endtask

  task automatic do_update(input logic [31:0] pc, input logic tk, input logic pd);
    upd_valid = 1'b1;
    upd_pc    = pc;
    upd_taken = tk;
    upd_pred  = pd;
    @(posedge clk);
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  // 26 not-taken reports of an untracked PC zero the history
  task automatic clear_hist();
    for (int k = 0; k < 26; k++) do_update(PC_C, 1'b0, 1'b0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 valid in reset", pred_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 valid after reset", pred_valid, 1'b0);

    for (int v = 0; v < 12; v++) begin
      if (VEC[v].upd) do_update(VEC[v].pc, VEC[v].tk, VEC[v].pd);
      else do_lookup(VEC[v].pc, $sformatf("R%0d vec %0d", VEC[v].req, v), VEC[v].exp);
    end

    // R6 threshold: three trainings reach sum -81, the fourth is confident
    clear_hist();
    for (int k = 0; k < 4; k++) do_update(PC_A, 1'b0, 1'b0);
    do_lookup(PC_A, "R5 sum -81", 1'b0);
    for (int k = 1; k <= 3; k++) begin
      do_update(PC_A, 1'b1, 1'b0);
      clear_hist();
      if (k == 2) do_lookup(PC_A, "R6 sum -27", 1'b0);
      if (k == 3) do_lookup(PC_A, "R6 no train above theta", 1'b1);
    end

    // R7 saturation: 40 forced trainings stop at bias -32, weights +31
    for (int k = 0; k < 40; k++) do_update(PC_A, 1'b0, 1'b1);
    do_lookup(PC_A, "R7 saturated low", 1'b0);
    for (int k = 1; k <= 32; k++) begin
      do_update(PC_A, 1'b1, 1'b0);
      clear_hist();
      if (k == 31) do_lookup(PC_A, "R7 sum -1", 1'b0);
      if (k == 32) do_lookup(PC_A, "R7 sum +26", 1'b1);
    end

    // R5 window: row now bias 0, weights -1, taken while ones <= 13
    for (int k = 0; k < 13; k++) do_update(PC_D, 1'b1, 1'b1);
    do_lookup(PC_A, "R5 13 ones", 1'b1);
    do_update(PC_D, 1'b1, 1'b1);
    do_lookup(PC_A, "R5 14 ones", 1'b0);
    for (int k = 0; k < 12; k++) do_update(PC_C, 1'b0, 1'b0);
    do_lookup(PC_A, "R5 ones at bits 12..25", 1'b0);
    do_update(PC_C, 1'b0, 1'b0);
    do_lookup(PC_A, "R5 bit 26 dropped", 1'b1);

    // R8 shared cycle drops the lookup
    lkp_valid = 1'b1;
    lkp_pc    = PC_D;
    upd_valid = 1'b1;
    upd_pc    = PC_C;
    upd_taken = 1'b0;
    upd_pred  = 1'b0;
    @(posedge clk);
    @(negedge clk);
    lkp_valid = 1'b0;
    upd_valid = 1'b0;
    check("R8 lookup dropped", pred_valid, 1'b0);
    do_lookup(PC_D, "R8 lookup after", 1'b1);

    // R9 reset clears the table
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 valid cleared", pred_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    do_lookup(PC_A, "R9 entry cleared", 1'b0);
    do_lookup(PC_D, "R9 entry cleared", 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule